// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects up to eight interrupt request lines into a pending register and hands the processor the start address of the right service routine. Each request line sets its own pending bit. The processor pulses an instruction-boundary strobe when it finishes an instruction. On that strobe the controller picks the most urgent pending source that may preempt the work already in service. It forms a table pointer by adding the source's vector number to a table base. It then reads the handler address through a one-port synchronous read interface and delivers that address with a single-cycle load-PC pulse.

Nesting is tracked with one in-service bit per source. A source can only start service if its priority is strictly above every level already in service. An end-of-service pulse retires the most urgent active level, which lets less urgent pending work through again. A global enable gates all dispatch without losing pending requests.

Top module: `irqv_top`

## Requirements
- R1: A high level on request line i in any clock cycle sets pending bit i. The bit stays set until its vector fetch completes. If the line is still high in the cycle the fetch completes, the bit stays set.
- R2: A dispatch starts only on a clock edge where the boundary strobe is high and no fetch is in progress. Pending requests cause no read request without a strobe.
- R3: Among pending sources, the lowest line index wins. Line 0 is the most urgent.
- R4: Source i may be dispatched only when no in-service bit at index i or lower is set. Equal and less urgent sources wait.
- R5: A dispatch raises rd_req for exactly one cycle, on the edge after the strobe. In that cycle rd_addr equals tbl_base plus the source index, with one table word per source.
- R6: rd_data is expected one cycle after rd_req. pc_load is high for exactly one cycle, two cycles after rd_req. In that cycle pc_value holds the returned word.
- R7: When the fetch completes, the selected pending bit clears (subject to R1) and the matching in-service bit is set.
- R8: An eos pulse clears the in-service bit with the lowest set index.
- R9: While glb_en is low no dispatch starts. Pending bits are kept and dispatch after enable returns.
- R10: Reset (synchronous, active high) clears pending and in-service bits and drives rd_req, pc_load, rd_addr and pc_value to zero.
- R11: A boundary strobe that arrives while a fetch is in progress is ignored and starts no second read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N | Interrupt request lines, line 0 most urgent |
| glb_en | input | 1 | Global dispatch enable |
| boundary | input | 1 | Instruction-boundary strobe |
| eos | input | 1 | End-of-service pulse |
| tbl_base | input | AW | Base word address of the vector table |
| rd_req | output | 1 | Table read request, one cycle |
| rd_addr | output | AW | Table read address |
| rd_data | input | DW | Table read data, valid one cycle after rd_req |
| pc_load | output | 1 | Load-PC pulse |
| pc_value | output | DW | Handler start address |

## Verification
The bench aims at the nesting rules. With a mid-priority source in service, an equal or lower source must stay blocked. A design that compares with less-or-equal instead of strictly-less would re-enter the same level. It also checks that end-of-service retires the most urgent level first. Popping the wrong bit would unblock a level too early or leave one stuck. A request line held high across its own fetch must survive the clear. A clear-wins design would drop that request. A strobe during an ongoing fetch must not start a second read, or a busy-blind design would emit a doubled request with a stale address.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  lines,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);
  logic [N-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  // a live request wins over the clear of the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | lines;
  end
endmodule

// File: rtl/irqv_inservice.sv
module irqv_inservice #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [N-1:0]  isr
);
  logic [N-1:0] nxt;
  logic         hit;

  always_comb begin
    nxt = isr;
    hit = 1'b0;
    if (pop) begin
      for (int i = 0; i < N; i++) begin
        if (!hit && isr[i]) begin
          nxt[i] = 1'b0;
          hit    = 1'b1;
        end
      end
    end
    if (push_en) nxt[push_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= nxt;
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  isr,
  output logic          grant_vld,
  output logic [IW-1:0] grant_idx
);
  logic blocked;

  // walk from most urgent; any active level at or above i blocks i
  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    blocked   = 1'b0;
    for (int i = 0; i < N; i++) begin
      blocked = blocked | isr[i];
      if (!grant_vld && !blocked && pend[i]) begin
        grant_vld = 1'b1;
        grant_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_lines,
  input  logic          glb_en,
  input  logic          boundary,
  input  logic          eos,
  input  logic [AW-1:0] tbl_base,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          pc_load,
  output logic [DW-1:0] pc_value
);
  import irqv_pkg::*;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  fetch_st_e     state;
  logic [IW-1:0] sel_idx;
  logic [N-1:0]  pend;
  logic [N-1:0]  isr;
  logic          grant_vld;
  logic [IW-1:0] grant_idx;
  logic          fetch_done;

  assign fetch_done = (state == ST_DATA);

  irqv_pending #(.N(N), .IW(IW)) u_pend (
    .clk(clk), .rst(rst), .lines(irq_lines),
    .clr_en(fetch_done), .clr_idx(sel_idx), .pend(pend)
  );

  irqv_inservice #(.N(N), .IW(IW)) u_isr (
    .clk(clk), .rst(rst), .push_en(fetch_done),
    .push_idx(sel_idx), .pop(eos), .isr(isr)
  );

  irqv_arbiter #(.N(N), .IW(IW)) u_arb (
    .pend(pend), .isr(isr), .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sel_idx  <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      pc_load  <= 1'b0;
      pc_value <= '0;
    end else begin
      rd_req  <= 1'b0;
      pc_load <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (boundary && glb_en && grant_vld) begin
            sel_idx <= grant_idx;
            rd_req  <= 1'b1;
            rd_addr <= tbl_base + AW'(grant_idx);
            state   <= ST_REQ;
          end
        end
        ST_REQ:  state <= ST_DATA;
        ST_DATA: begin
          pc_value <= rd_data;
          pc_load  <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          glb_en,
  input logic          boundary,
  input logic          rd_req,
  input logic          pc_load,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] pc_value
);
  // R5: read request is a single-cycle pulse
  p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R6: load-PC follows the read request by two cycles
  p_load_after_req_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##2 pc_load);

  // R6: load-PC lasts one cycle and carries the returned word
  p_load_single_r6: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load);

  p_load_value_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pc_load) |-> pc_value == $past(rd_data));

  // R2, R9: a read only follows an enabled boundary strobe
  p_req_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> $past(boundary) && $past(glb_en));

  // R11: no new request while one fetch is pending
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req ##1 !rd_req);
endmodule

bind irqv_top irqv_checker #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .boundary(boundary),
  .rd_req(rd_req), .pc_load(pc_load), .rd_data(rd_data), .pc_value(pc_value)
);

// File: tb/tb_irqv_top.sv
module tb_irqv_top;
  localparam int N = 8;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_lines = '0;
  logic          glb_en = 1'b0;
  logic          boundary = 1'b0;
  logic          eos = 1'b0;
  logic [AW-1:0] tbl_base = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          pc_load;
  logic [DW-1:0] pc_value;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irqv_top #(.N(N), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .glb_en(glb_en),
    .boundary(boundary), .eos(eos), .tbl_base(tbl_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .pc_load(pc_load), .pc_value(pc_value)
  );

  function automatic logic [DW-1:0] tbl_word(input logic [AW-1:0] a);
    return DW'(a * 16'h0111) ^ 16'hC35A;
  endfunction

  // vector table model: one cycle read latency
  always @(posedge clk) if (rd_req) rd_data <= tbl_word(rd_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic raise(input logic [N-1:0] m);
    tick(); irq_lines = m;
    tick(); irq_lines = '0;
  endtask

  task automatic end_service();
    tick(); eos = 1'b1;
    tick(); eos = 1'b0;
  endtask

  task automatic dispatch(input int src, input bit busy_strobe);
    logic [AW-1:0] a;
    a = tbl_base + AW'(src);
    tick(); boundary = 1'b1;
    tick(); boundary = busy_strobe;
    chk($sformatf("R5 rd_req src%0d", src), 32'(rd_req), 32'd1);
    chk($sformatf("R3 R5 rd_addr src%0d", src), 32'(rd_addr), 32'(a));
    tick(); boundary = 1'b0;
    chk("R11 rd_req single", 32'(rd_req), 32'd0);
    tick();
    chk($sformatf("R6 pc_load src%0d", src), 32'(pc_load), 32'd1);
    chk($sformatf("R6 pc_value src%0d", src), 32'(pc_value), 32'(tbl_word(a)));
    tick();
    chk("R6 pc_load width", 32'(pc_load), 32'd0);
    chk("R11 no second read", 32'(rd_req), 32'd0);
  endtask

  task automatic expect_none(input string req);
    bit seen;
    seen = 1'b0;
    tick(); boundary = 1'b1;
    tick(); boundary = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (rd_req || pc_load) seen = 1'b1;
      tick();
    end
    chk(req, 32'(seen), 32'd0);
  endtask

  localparam logic [N-1:0] VEC [6] = '{8'h01, 8'h80, 8'h81, 8'hA5, 8'h3C, 8'hFF};

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) tick();
    // R10: reset state
    chk("R10 rd_req", 32'(rd_req), 32'd0);
    chk("R10 pc_load", 32'(pc_load), 32'd0);
    chk("R10 rd_addr", 32'(rd_addr), 32'd0);
    chk("R10 pc_value", 32'(pc_value), 32'd0);
    rst = 1'b0;
    glb_en = 1'b1;

    // R3, R7: vector walk, each mask served in ascending index order
    for (int v = 0; v < 6; v++) begin
      tbl_base = AW'(16'h0100 * (v + 1));
      raise(VEC[v]);
      for (int b = 0; b < N; b++) begin
        if (VEC[v][b]) begin
          dispatch(b, 1'b0);
          end_service();
        end
      end
      expect_none("R7 pending cleared after service");
    end

    // R2: pending requests without a strobe stay idle
    tbl_base = 16'h2000;
    raise(8'h10);
    begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 6; k++) begin
        if (rd_req) seen = 1'b1;
        tick();
      end
      chk("R2 no read without strobe", 32'(seen), 32'd0);
    end
    dispatch(4, 1'b0);
    end_service();

    // R9: disabled controller keeps pending bits
    glb_en = 1'b0;
    raise(8'h40);
    expect_none("R9 disabled no dispatch");
    glb_en = 1'b1;
    dispatch(6, 1'b0);
    end_service();

    // R11: strobe during fetch ignored while another source waits
    raise(8'h0A);
    dispatch(1, 1'b1);
    end_service();
    dispatch(3, 1'b0);
    end_service();

    // R4, R8: nesting
    raise(8'h10);
    dispatch(4, 1'b0);                       // 4 in service
    raise(8'h20);
    expect_none("R4 lower blocked");
    raise(8'h10);
    expect_none("R4 equal blocked");
    raise(8'h04);
    dispatch(2, 1'b0);                       // preempts: 2 and 4 in service
    expect_none("R4 blocked under two levels");
    end_service();                           // R8 retires 2
    expect_none("R8 level 4 still active");
    end_service();                           // retires 4
    dispatch(4, 1'b0);
    end_service();
    dispatch(5, 1'b0);
    end_service();

    // R1: line held high across its fetch stays pending
    tick(); irq_lines = 8'h08;
    dispatch(3, 1'b0);
    irq_lines = '0;
    end_service();
    dispatch(3, 1'b0);
    end_service();
    expect_none("R1 request consumed");

    summary();
  end
endmodule